// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Qualifier

This block sits beside one serial channel and follows how full its two 8-entry character queues are: the receive queue (characters waiting for the host) and the transmit queue (characters waiting to be sent). It does not store characters. It sees only the push and pop strobes of each queue and keeps an occupancy counter for each.

From these counters and two programmed 2-bit level codes, it decides whether each direction may take part in interrupt arbitration. A receive bid is allowed once enough characters are held. A transmit bid is allowed once enough slots are free and the transmitter is enabled. The level codes change only eligibility: each queue still accepts eight characters whatever the code. The receive code is assembled from single bits that live in two different mode registers.

The block also drives the byte count that the global byte-count register shows. For a receive interrupt this is the number of characters held, for a transmit interrupt the number of open slots, and for any other interrupt kind all ones.

Top module: `fill_bid_qualifier`

## Requirements
- R1: While reset is asserted and after its release, the receive queue holds 0 characters and the transmit queue reports 8 free slots; both overrun outputs are low.
- R2: The receive code is {rx_code_msb, rx_code_lsb}. rx_bid_en is high when the characters held reach at least 1 (code 00), 3 (code 01), 6 (code 10) or 8 (code 11), and low otherwise.
- R3: tx_bid_en (with tx_enable high) is high when the free transmit slots reach at least 8 (tx_code 00), 4 (01), 6 (10) or 1 (11), and low otherwise.
- R4: tx_bid_en is low whenever tx_enable is low, whatever the occupancy and code.
- R5: With tx_code 00 and an empty transmit queue, a single transmit push withdraws tx_bid_en in the cycle after the push edge.
- R6: Each queue accepts exactly 8 pushes regardless of its code. A push to a full queue without a pop in the same cycle leaves the count at 8 and raises that queue's overrun output for exactly one cycle after the edge.
- R7: A pop from an empty queue without a push in the same cycle leaves the occupancy at 0.
- R8: A push and a pop in the same cycle leave a non-empty queue's occupancy unchanged, including when it is full (no overrun). On an empty queue the push is taken and the pop is ignored, giving 1.
- R9: byte_count shows the receive characters held when ctx_sel is 00, the transmit free slots when ctx_sel is 01, and all ones (15) when ctx_sel is 10 or 11.
- R10: Occupancy, byte_count and the bid enables change only on the clock edge that samples a push or pop, and are visible one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_push | input | 1 | A character was written into the receive queue |
| rx_pop | input | 1 | The host read a character from the receive queue |
| tx_push | input | 1 | The host wrote a character into the transmit queue |
| tx_pop | input | 1 | The transmitter took a character from the transmit queue |
| rx_code_msb | input | 1 | Upper bit of the receive level code (from the first mode register) |
| rx_code_lsb | input | 1 | Lower bit of the receive level code (from the second mode register) |
| tx_code | input | 2 | Transmit level code |
| tx_enable | input | 1 | Transmitter enabled; gates the transmit bid |
| ctx_sel | input | 2 | Kind of the latched interrupt: 00 receive, 01 transmit, 1x other |
| rx_bid_en | output | 1 | Receive side may bid |
| tx_bid_en | output | 1 | Transmit side may bid |
| byte_count | output | 4 | Count for the global byte-count register |
| rx_overrun | output | 1 | One-cycle pulse: a receive push was dropped |
| tx_overrun | output | 1 | One-cycle pulse: a transmit push was dropped |

## Verification
A counter that drifts by one shows at byte_count in the cycle after the bad strobe, once ctx_sel points at that direction. It also flips the bid enable at a threshold crossing one push early or late. Because the table steps each counter through every value from empty to full under codes that change along the way, a wrong threshold or a miscounted edge case (full with a push, empty with a pop, both strobes together) is caught within one cycle of the strobe that exposes it. A dropped or stretched overrun pulse shows at the overrun output in the single cycle after the push into a full queue.

// File: rtl/fbq_pkg.sv
package fbq_pkg;

  // Direction of a queue: receive counts characters held, transmit counts free slots.
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // Kind of the interrupt latched by the arbiter; picks what byte_count reports.
  typedef enum logic [1:0] {
    CTX_RX    = 2'b00,
    CTX_TX    = 2'b01,
    CTX_MISC0 = 2'b10,
    CTX_MISC1 = 2'b11
  } ctx_e;

  // Level needed for a bid, scaled from the 8-deep case to any depth.
  function automatic int unsigned threshold_of(input dir_e dir, input logic [1:0] code,
                                               input int unsigned depth);
    int unsigned t;
    if (dir == DIR_RX) begin
      case (code)
        2'd0:    t = 1;
        2'd1:    t = (3 * depth) / 8;
        2'd2:    t = (6 * depth) / 8;
        default: t = depth;
      endcase
    end else begin
      case (code)
        2'd0:    t = depth;
        2'd1:    t = depth / 2;
        2'd2:    t = (3 * depth) / 4;
        default: t = 1;
      endcase
    end
    if (t == 0) t = 1;
    return t;
  endfunction

endpackage

// File: rtl/fbq_rst_sync.sv
module fbq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/fbq_occupancy.sv
module fbq_occupancy #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] held,
  output logic          overrun
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] held_q, held_d;
  logic          ovr_q, ovr_d;
  logic          full, empty, take_push, take_pop, held_en;

  always_comb begin
    full      = (held_q == FULL_CNT);
    empty     = (held_q == '0);
    // A full queue takes a push only when a pop frees a slot in the same cycle.
    take_push = push && (!full || pop);
    // An empty queue has nothing to give back.
    take_pop  = pop && !empty;
    held_en   = take_push ^ take_pop;
    held_d    = held_q;
    if (take_push && !take_pop) begin
      held_d = held_q + CW'(1);
    end else if (take_pop && !take_push) begin
      held_d = held_q - CW'(1);
    end
    ovr_d = push && full && !pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  assign held    = held_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/fbq_level_decode.sv
module fbq_level_decode #(
  parameter int unsigned  DEPTH = 8,
  parameter fbq_pkg::dir_e DIR  = fbq_pkg::DIR_RX,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] held,
  input  logic [1:0]    code,
  input  logic          gate,
  output logic [CW-1:0] level,
  output logic          bid
);

  logic [CW-1:0] thr_tab [4];
  logic [CW-1:0] thr;

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr_tab[g] = CW'(fbq_pkg::threshold_of(DIR, 2'(g), DEPTH));
  end

  if (DIR == fbq_pkg::DIR_RX) begin : g_rx_level
    assign level = held;
  end else begin : g_tx_level
    assign level = CW'(DEPTH) - held;
  end

  always_comb begin
    thr = thr_tab[code];
    bid = gate && (level >= thr);
  end

endmodule

// File: rtl/fill_bid_qualifier.sv
module fill_bid_qualifier #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          tx_push,
  input  logic          tx_pop,
  input  logic          rx_code_msb,
  input  logic          rx_code_lsb,
  input  logic [1:0]    tx_code,
  input  logic          tx_enable,
  input  logic [1:0]    ctx_sel,
  output logic          rx_bid_en,
  output logic          tx_bid_en,
  output logic [CW-1:0] byte_count,
  output logic          rx_overrun,
  output logic          tx_overrun
);

  import fbq_pkg::*;

  logic          rst_sync_n;
  logic [CW-1:0] rx_held, tx_held;
  logic [CW-1:0] rx_level, tx_level;
  logic [1:0]    rx_code;
  ctx_e          ctx;

  fbq_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  fbq_occupancy #(.DEPTH(DEPTH)) u_rx_occ (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .push   (rx_push),
    .pop    (rx_pop),
    .held   (rx_held),
    .overrun(rx_overrun)
  );

  fbq_occupancy #(.DEPTH(DEPTH)) u_tx_occ (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .push   (tx_push),
    .pop    (tx_pop),
    .held   (tx_held),
    .overrun(tx_overrun)
  );

  // Receive code bits come from two separate mode registers.
  assign rx_code = {rx_code_msb, rx_code_lsb};

  fbq_level_decode #(.DEPTH(DEPTH), .DIR(DIR_RX)) u_rx_dec (
    .held (rx_held),
    .code (rx_code),
    .gate (1'b1),
    .level(rx_level),
    .bid  (rx_bid_en)
  );

  fbq_level_decode #(.DEPTH(DEPTH), .DIR(DIR_TX)) u_tx_dec (
    .held (tx_held),
    .code (tx_code),
    .gate (tx_enable),
    .level(tx_level),
    .bid  (tx_bid_en)
  );

  always_comb begin
    ctx = ctx_e'(ctx_sel);
    case (ctx)
      CTX_RX:  byte_count = rx_level;
      CTX_TX:  byte_count = tx_level;
      default: byte_count = '1;
    endcase
  end

endmodule

// File: rtl/fbq_checker.sv
module fbq_checker #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          rx_code_msb,
  input logic          rx_code_lsb,
  input logic [1:0]    tx_code,
  input logic          tx_enable,
  input logic [1:0]    ctx_sel,
  input logic          rx_bid_en,
  input logic          tx_bid_en,
  input logic [CW-1:0] byte_count,
  input logic          rx_overrun,
  input logic          tx_overrun,
  input logic [CW-1:0] rx_held,
  input logic [CW-1:0] tx_held
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // R6: occupancy never passes the queue depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_held <= FULL_CNT) && (tx_held <= FULL_CNT));

  // R6: push into a full receive queue is dropped and flagged next cycle
  p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_held == FULL_CNT) |=> (rx_overrun && rx_held == FULL_CNT));

  // R6: overrun pulse only follows a dropped push
  p_tx_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |-> $past(tx_push && !tx_pop && tx_held == FULL_CNT));

  // R7: pop from an empty queue leaves it empty
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push && rx_held == '0) |=> (rx_held == '0));

  // R4: disabled transmitter never bids
  p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !tx_bid_en);

  // R5: default code, one push into an empty queue withdraws the bid
  p_withdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == 2'b00 && tx_push && !tx_pop && tx_held == '0) |=> !tx_bid_en);

  // R2: code 11 bids only on a full receive queue
  p_rx_full_bid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_code_msb && rx_code_lsb && rx_bid_en) |-> (rx_held == FULL_CNT));

  // R9: non-data contexts report all ones
  p_misc_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_sel[1] |-> (byte_count == '1));

  // R10: no strobe, no change of occupancy
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_push && !rx_pop && !tx_push && !tx_pop) |=> ($stable(rx_held) && $stable(tx_held)));

endmodule

bind fill_bid_qualifier fbq_checker #(.DEPTH(DEPTH)) u_fbq_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .tx_push    (tx_push),
  .tx_pop     (tx_pop),
  .rx_code_msb(rx_code_msb),
  .rx_code_lsb(rx_code_lsb),
  .tx_code    (tx_code),
  .tx_enable  (tx_enable),
  .ctx_sel    (ctx_sel),
  .rx_bid_en  (rx_bid_en),
  .tx_bid_en  (tx_bid_en),
  .byte_count (byte_count),
  .rx_overrun (rx_overrun),
  .tx_overrun (tx_overrun),
  .rx_held    (rx_held),
  .tx_held    (tx_held)
);

// File: tb/fill_bid_qualifier_test.sv
module fill_bid_qualifier_test;

  typedef struct packed {
    logic       rp;
    logic       rpo;
    logic       tp;
    logic       tpo;
    logic [1:0] rc;
    logic [1:0] tc;
    logic       te;
    logic [1:0] ctx;
    logic [3:0] cnt;
    logic       rb;
    logic       tb;
    logic       rov;
    logic       tov;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(int rp, int rpo, int tp, int tpo, int rc, int tc, int te,
                              int ctx, int cnt, int rb, int tb, int rov, int tov, int req);
    vec_t v;
    v.rp = 1'(rp);   v.rpo = 1'(rpo); v.tp = 1'(tp);   v.tpo = 1'(tpo);
    v.rc = 2'(rc);   v.tc = 2'(tc);   v.te = 1'(te);   v.ctx = 2'(ctx);
    v.cnt = 4'(cnt); v.rb = 1'(rb);   v.tb = 1'(tb);
    v.rov = 1'(rov); v.tov = 1'(tov); v.req = 4'(req);
    return v;
  endfunction

  localparam int NV = 45;
  // fields: rx_push rx_pop tx_push tx_pop rx_code tx_code tx_en ctx | count rx_bid tx_bid rx_ovr tx_ovr | req
  localparam vec_t VEC [NV] = '{
    mk(0,0,0,0, 0,0,1,0,  0,0,1,0,0, 1),  // R1 empty receive
    mk(0,0,0,0, 0,0,1,1,  8,0,1,0,0, 1),  // R1 eight free
    mk(0,0,0,0, 0,0,0,1,  8,0,0,0,0, 4),  // R4 disabled
    mk(0,0,1,0, 0,0,1,1,  7,0,0,0,0, 5),  // R5 withdraw
    mk(0,0,0,1, 0,0,1,1,  8,0,1,0,0, 3),  // R3 back to empty
    mk(1,0,0,0, 0,0,1,0,  1,1,1,0,0, 2),  // R2 code 00
    mk(1,0,0,0, 1,0,1,0,  2,0,1,0,0, 2),  // R2 code 01 below
    mk(1,0,0,0, 1,0,1,0,  3,1,1,0,0, 2),  // R2 code 01 at 3
    mk(1,0,0,0, 2,0,1,0,  4,0,1,0,0, 2),  // R2 code 10
    mk(1,0,0,0, 2,0,1,0,  5,0,1,0,0, 2),
    mk(1,0,0,0, 2,0,1,0,  6,1,1,0,0, 2),  // R2 code 10 at 6
    mk(1,0,0,0, 3,0,1,0,  7,0,1,0,0, 2),  // R2 code 11
    mk(1,0,0,0, 3,0,1,0,  8,1,1,0,0, 6),  // R6 eighth accepted
    mk(1,0,0,0, 3,0,1,0,  8,1,1,1,0, 6),  // R6 dropped push
    mk(1,1,0,0, 3,0,1,0,  8,1,1,0,0, 8),  // R8 full both strobes
    mk(0,0,0,0, 3,0,1,2, 15,1,1,0,0, 9),  // R9 other kind
    mk(0,0,0,0, 3,0,1,3, 15,1,1,0,0, 9),  // R9 other kind
    mk(0,0,1,0, 3,1,1,1,  7,1,1,0,0, 3),  // R3 code 01
    mk(0,0,1,0, 3,1,1,1,  6,1,1,0,0, 3),
    mk(0,0,1,0, 3,1,1,1,  5,1,1,0,0, 3),
    mk(0,0,1,0, 3,1,1,1,  4,1,1,0,0, 3),  // R3 at 4
    mk(0,0,1,0, 3,1,1,1,  3,1,0,0,0, 3),  // R3 below 4
    mk(0,0,0,0, 3,2,1,1,  3,1,0,0,0, 3),  // R3 code 10
    mk(0,0,0,1, 3,2,1,1,  4,1,0,0,0, 3),
    mk(0,0,0,1, 3,2,1,1,  5,1,0,0,0, 3),
    mk(0,0,0,1, 3,2,1,1,  6,1,1,0,0, 3),  // R3 at 6
    mk(0,0,0,0, 3,3,1,1,  6,1,1,0,0, 3),  // R3 code 11
    mk(0,0,1,0, 3,3,1,1,  5,1,1,0,0, 3),
    mk(0,0,1,0, 3,3,1,1,  4,1,1,0,0, 3),
    mk(0,0,1,0, 3,3,1,1,  3,1,1,0,0, 3),
    mk(0,0,1,0, 3,3,1,1,  2,1,1,0,0, 3),
    mk(0,0,1,0, 3,3,1,1,  1,1,1,0,0, 3),  // R3 at 1
    mk(0,0,1,0, 3,3,1,1,  0,1,0,0,0, 6),  // R6 eighth transmit push
    mk(0,0,1,0, 3,3,1,1,  0,1,0,0,1, 6),  // R6 dropped transmit push
    mk(0,0,1,1, 3,3,1,1,  0,1,0,0,0, 8),  // R8 full both strobes
    mk(0,1,0,0, 0,3,1,0,  7,1,0,0,0, 10), // R10 pop steps down
    mk(0,1,0,0, 0,3,1,0,  6,1,0,0,0, 10),
    mk(0,1,0,0, 0,3,1,0,  5,1,0,0,0, 10),
    mk(0,1,0,0, 0,3,1,0,  4,1,0,0,0, 10),
    mk(0,1,0,0, 0,3,1,0,  3,1,0,0,0, 10),
    mk(0,1,0,0, 0,3,1,0,  2,1,0,0,0, 10),
    mk(0,1,0,0, 0,3,1,0,  1,1,0,0,0, 10),
    mk(0,1,0,0, 0,3,1,0,  0,0,0,0,0, 2),  // R2 empty no bid
    mk(0,1,0,0, 0,3,1,0,  0,0,0,0,0, 7),  // R7 pop when empty
    mk(1,1,0,0, 0,3,1,0,  1,1,0,0,0, 8)   // R8 empty both strobes
  };

  logic       clk, rst_n;
  logic       rx_push, rx_pop, tx_push, tx_pop;
  logic       rx_code_msb, rx_code_lsb, tx_enable;
  logic [1:0] tx_code, ctx_sel;
  logic       rx_bid_en, tx_bid_en, rx_overrun, tx_overrun;
  logic [3:0] byte_count;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  fill_bid_qualifier uut (
    .clk(clk), .rst_n(rst_n),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_code_msb(rx_code_msb), .rx_code_lsb(rx_code_lsb),
    .tx_code(tx_code), .tx_enable(tx_enable), .ctx_sel(ctx_sel),
    .rx_bid_en(rx_bid_en), .tx_bid_en(tx_bid_en), .byte_count(byte_count),
    .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] rc, input logic [1:0] tc, input logic te,
                         input logic [1:0] ctx);
    {rx_code_msb, rx_code_lsb} = rc;
    tx_code   = tc;
    tx_enable = te;
    ctx_sel   = ctx;
  endtask

  // Strobes are driven at the falling edge, taken at the rising edge, and
  // results are sampled 1 ns later with the strobes already dropped.
  task automatic apply(input vec_t v);
    @(negedge clk);
    rx_push = v.rp; rx_pop = v.rpo; tx_push = v.tp; tx_pop = v.tpo;
    set_cfg(v.rc, v.tc, v.te, v.ctx);
    @(posedge clk);
    #1;
    rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
    set_cfg(2'd0, 2'd0, 1'b1, 2'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rx count", int'(byte_count), 0);
    chk("R1 reset rx bid", int'(rx_bid_en), 0);
    chk("R1 reset rx overrun", int'(rx_overrun), 0);
    chk("R1 reset tx overrun", int'(tx_overrun), 0);
    ctx_sel = 2'd1;
    #1;
    chk("R1 reset tx free", int'(byte_count), 8);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      string tag;
      apply(VEC[i]);
      tag = $sformatf("R%0d row %0d", VEC[i].req, i);
      chk({tag, " count"},  int'(byte_count), int'(VEC[i].cnt));
      chk({tag, " rx bid"}, int'(rx_bid_en),  int'(VEC[i].rb));
      chk({tag, " tx bid"}, int'(tx_bid_en),  int'(VEC[i].tb));
      chk({tag, " rx ovr"}, int'(rx_overrun), int'(VEC[i].rov));
      chk({tag, " tx ovr"}, int'(tx_overrun), int'(VEC[i].tov));
    end

    // R4: one free slot with code 11 bids only while enabled.
    apply(mk(0,0,0,1, 0,3,0,1, 1,1,0,0,0, 4));
    chk("R4 disabled with free slot", int'(tx_bid_en), 0);
    chk("R4 free slot count", int'(byte_count), 1);
    #1 tx_enable = 1'b1;
    #1 chk("R4 enabled with free slot", int'(tx_bid_en), 1);

    // R10: count holds across idle cycles.
    ctx_sel = 2'd0;
    repeat (3) @(posedge clk);
    #1 chk("R10 rx count holds", int'(byte_count), 1);

    // R1: reset in mid-run clears both queues at once.
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 mid-run reset rx", int'(byte_count), 0);
    ctx_sel = 2'd1;
    #1 chk("R1 mid-run reset tx", int'(byte_count), 8);
    chk("R1 mid-run reset tx bid", int'(tx_bid_en), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 after release tx", int'(byte_count), 8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule